// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This unit turns a logical address into a physical one by segment lookup. Each request carries a segment number, an offset and an access kind. The unit first compares the segment number against a held table-length register. When the segment is in range, it fetches that segment's descriptor word from memory. The fetch address is a held table-base register plus eight bytes per segment. The unit then checks the descriptor and answers with either a physical address or a fault code.

Requests and responses use valid/ready handshakes, with one translation in flight at a time. `req_ready` is high only while the unit is idle. A response stays on the pins, unchanged, until `resp_ready` takes it, so a stalled consumer blocks new requests. The descriptor fetch also has a valid/ready request channel. Its response channel has no back-pressure, because the unit always waits for it. The two table registers load through plain pins.

Top module: `segx_top`

## Requirements
- R1: At most one translation is in flight. `req_ready` is high only when no request is held and no response is pending. While `resp_valid` is high and `resp_ready` is low, `resp_fault` and `resp_paddr` hold their values.
- R2: A segment number not below the loaded table length gives fault code 1. No descriptor fetch is issued for it.
- R3: A legal segment number issues exactly one descriptor fetch at `table_base + seg*8`, taken modulo 2^32. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is high.
- R4: Descriptor word layout: bits 31:0 hold the segment base, bits 47:32 the segment length, bit 48 the valid flag, bit 49 read permission, bit 50 write permission and bit 51 execute permission. Bits 63:52 are ignored.
- R5: A descriptor whose valid flag is 0 gives fault code 2.
- R6: An offset greater than or equal to the segment length gives fault code 3. An offset of length minus one is legal.
- R7: The access kind is 0 for read, 1 for write and 2 for execute. Each needs its matching permission bit. Code 3 is always refused. A refusal gives fault code 4.
- R8: On success the fault code is 0 and the physical address is base plus offset, modulo 2^32. Any fault returns a physical address of 0.
- R9: When several faults apply, the reported one follows this order: range (1), then valid (2), then length (3), then permission (4).
- R10: `resp_valid` rises on the cycle after the descriptor arrives (`mem_rsp_valid`). For a range fault it rises on the cycle after the request is accepted.
- R11: After reset, `req_ready` is 1, `resp_valid` and `mem_req_valid` are 0, and the table length is 0. Until the registers are loaded, every request gives fault code 1.
- R12: A cycle with `cfg_load` high sets the table base and table length for all later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load the table base and table length |
| cfg_tbl_base | input | 32 | Byte address of descriptor 0 |
| cfg_tbl_len | input | 17 | Number of segments in the table |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_seg | input | 16 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| mem_req_valid | output | 1 | Descriptor fetch requested |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor word returned |
| mem_rsp_data | input | 64 | Descriptor word |
| resp_valid | output | 1 | Result present |
| resp_ready | input | 1 | Consumer takes the result |
| resp_fault | output | 3 | 0 success, 1 range, 2 invalid, 3 length, 4 permission |
| resp_paddr | output | 32 | Physical address, 0 on fault |

## Verification
The bench builds the unit with its default widths: a 16-bit segment number, a 16-bit offset, a 32-bit physical address and 64-bit descriptors. These sizes let one request reach both the largest segment number (65535) and a base near the top of the address space. That brings the range check at its extreme and the modulo-2^32 wrap of base plus offset within reach. The memory model withholds `mem_req_ready` on some cycles and answers with a fixed delay. The consumer drops `resp_ready` in a repeating pattern, so both back-pressure paths and the held-response rule get exercised.

// File: rtl/segx_pkg.sv
package segx_pkg;
  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_RANGE  = 3'd1,
    FLT_INVAL  = 3'd2,
    FLT_BOUNDS = 3'd3,
    FLT_PERM   = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD   = 2'd0,
    ACC_WR   = 2'd1,
    ACC_EX   = 2'd2,
    ACC_RSVD = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } state_e;
endpackage

// File: rtl/segx_range.sv
module segx_range #(
  parameter int SEG_W = 16
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [SEG_W:0]   tbl_len,
  output logic             legal
);
  // Segment count may equal 2^SEG_W, hence one extra bit on the length.
  assign legal = ({1'b0, seg} < tbl_len);
endmodule

// File: rtl/segx_check.sv
module segx_check
  import segx_pkg::*;
#(
  parameter int PA_W    = 32,
  parameter int OFF_W   = 16,
  parameter int ENTRY_W = 64
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [OFF_W-1:0]   off,
  input  logic [1:0]         acc,
  output logic [2:0]         fault,
  output logic [PA_W-1:0]    paddr
);
  localparam int LIM_LSB = PA_W;
  localparam int V_BIT   = PA_W + OFF_W;
  localparam int R_BIT   = V_BIT + 1;
  localparam int W_BIT   = V_BIT + 2;
  localparam int X_BIT   = V_BIT + 3;

  logic [PA_W-1:0]  seg_base;
  logic [OFF_W-1:0] seg_lim;
  logic             allowed;

  assign seg_base = entry[PA_W-1:0];
  assign seg_lim  = entry[LIM_LSB +: OFF_W];

  always_comb begin
    case (acc_e'(acc))
      ACC_RD:  allowed = entry[R_BIT];
      ACC_WR:  allowed = entry[W_BIT];
      ACC_EX:  allowed = entry[X_BIT];
      default: allowed = 1'b0;
    endcase
  end

  always_comb begin
    paddr = '0;
    if (!entry[V_BIT])          fault = FLT_INVAL;
    else if (off >= seg_lim)    fault = FLT_BOUNDS;
    else if (!allowed)          fault = FLT_PERM;
    else begin
      fault = FLT_NONE;
      paddr = seg_base + PA_W'(off);
    end
  end
endmodule

// File: rtl/segx_top.sv
module segx_top
  import segx_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int PA_W    = 32,
  parameter int ENTRY_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [PA_W-1:0]    cfg_tbl_base,
  input  logic [SEG_W:0]     cfg_tbl_len,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [SEG_W-1:0]   req_seg,
  input  logic [OFF_W-1:0]   req_off,
  input  logic [1:0]         req_acc,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic [2:0]         resp_fault,
  output logic [PA_W-1:0]    resp_paddr
);
  localparam int ENT_LG2 = $clog2(ENTRY_W / 8);

  state_e            st_q;
  logic [PA_W-1:0]   tbl_base_q;
  logic [SEG_W:0]    tbl_len_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        acc_q;
  logic [PA_W-1:0]   addr_q;
  logic [2:0]        fault_q;
  logic [PA_W-1:0]   pa_q;

  logic              seg_legal;
  logic [2:0]        chk_fault;
  logic [PA_W-1:0]   chk_pa;
  logic [PA_W-1:0]   ent_addr;

  segx_range #(.SEG_W(SEG_W)) u_range (
    .seg     (req_seg),
    .tbl_len (tbl_len_q),
    .legal   (seg_legal)
  );

  segx_check #(.PA_W(PA_W), .OFF_W(OFF_W), .ENTRY_W(ENTRY_W)) u_check (
    .entry (mem_rsp_data),
    .off   (off_q),
    .acc   (acc_q),
    .fault (chk_fault),
    .paddr (chk_pa)
  );

  assign ent_addr = tbl_base_q + (PA_W'(req_seg) << ENT_LG2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_base_q <= '0;
      tbl_len_q  <= '0;
    end else if (cfg_load) begin
      tbl_base_q <= cfg_tbl_base;
      tbl_len_q  <= cfg_tbl_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      off_q   <= '0;
      acc_q   <= '0;
      addr_q  <= '0;
      fault_q <= '0;
      pa_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          off_q <= req_off;
          acc_q <= req_acc;
          if (seg_legal) begin
            addr_q <= ent_addr;
            st_q   <= ST_FETCH;
          end else begin
            fault_q <= FLT_RANGE;
            pa_q    <= '0;
            st_q    <= ST_RESP;
          end
        end
        ST_FETCH: if (mem_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          fault_q <= chk_fault;
          pa_q    <= chk_pa;
          st_q    <= ST_RESP;
        end
        ST_RESP: if (resp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_FETCH);
  assign mem_req_addr  = addr_q;
  assign resp_valid    = (st_q == ST_RESP);
  assign resp_fault    = fault_q;
  assign resp_paddr    = pa_q;

  // R1: one in flight, held result under back-pressure
  p_single_flight_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid || mem_req_valid) |-> !req_ready);
  p_resp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_fault) && $stable(resp_paddr)));
  // R2: out-of-range segment skips the fetch
  p_range_no_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !seg_legal) |=> (!mem_req_valid && resp_valid && resp_fault == 3'd1));
  // R3: fetch request held until taken
  p_fetch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R8: faulted responses carry a zero address
  p_fault_zero_pa_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault != 3'd0) |-> (resp_paddr == '0));
  // R10: result follows the descriptor by one cycle
  p_resp_after_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && mem_rsp_valid) |=> resp_valid);
  // R9: only defined codes appear
  p_code_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_fault <= 3'd4));
endmodule

// File: tb/tb_segx_top.sv
module tb_segx_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TBASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_tbl_base = '0;
  logic [16:0] cfg_tbl_len = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_seg = '0;
  logic [15:0] req_off = '0;
  logic [1:0]  req_acc = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        resp_valid;
  logic        resp_ready;
  logic [2:0]  resp_fault;
  logic [31:0] resp_paddr;

  int checks = 0;
  int errors = 0;
  int fetches = 0;
  int exp_fetches = 0;

  typedef struct { logic [2:0] f; logic [31:0] pa; string tag; } exp_t;
  exp_t        sb_q[$];
  logic [31:0] addr_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  segx_top dut (.*);

  function automatic logic [63:0] mk(logic [31:0] b, logic [15:0] l, bit v, bit r, bit w, bit x);
    return {12'hABC, x, w, r, v, l, b};
  endfunction

  logic [63:0] tbl [0:7];
  initial begin
    tbl[0] = mk(32'h0010_0000, 16'h0100, 1, 1, 1, 0);
    tbl[1] = mk(32'h0020_0000, 16'h0800, 1, 1, 0, 1);
    tbl[2] = mk(32'h0030_0000, 16'h0000, 0, 1, 1, 1);
    tbl[3] = mk(32'hFFFF_FF00, 16'hFFFF, 1, 1, 1, 1);
    tbl[4] = mk(32'h0040_0000, 16'h0010, 1, 0, 0, 0);
    tbl[5] = mk(32'h0050_0000, 16'h0100, 1, 1, 1, 1);
    tbl[6] = '0;
    tbl[7] = '0;
  end

  // Memory model: stalls its request channel, answers two cycles after acceptance
  int        cyc = 0;
  int        dly = 0;
  bit        pend = 0;
  logic [63:0] data_q;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 4 != 1);
    resp_ready    <= (cyc % 5 != 2) && (cyc % 5 != 3);
    mem_rsp_valid <= 1'b0;
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      resp_ready    <= 1'b0;
      pend <= 0;
    end else if (mem_req_valid && mem_req_ready) begin
      logic [31:0] ea;
      fetches <= fetches + 1;
      ea = (addr_q.size() > 0) ? addr_q.pop_front() : 32'hDEAD_BEEF;
      checks <= checks + 1;
      if (mem_req_addr !== ea) begin
        errors <= errors + 1;
        $display("FAIL R3 fetch address actual=%h expected=%h", mem_req_addr, ea);
      end
      data_q <= tbl[mem_req_addr[5:3]];
      pend <= 1;
      dly  <= 1;
    end else if (pend) begin
      if (dly == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= data_q;
        pend <= 0;
      end else dly <= dly - 1;
    end
  end

  // Monitor: handshake at next posedge is visible at negedge
  always @(negedge clk) begin
    if (rst_n && resp_valid && resp_ready) begin
      exp_t e;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected response actual=%0d/%h expected=none", resp_fault, resp_paddr);
      end else begin
        e = sb_q.pop_front();
        if (resp_fault !== e.f || resp_paddr !== e.pa) begin
          errors++;
          $display("FAIL %s actual=%0d/%h expected=%0d/%h", e.tag, resp_fault, resp_paddr, e.f, e.pa);
        end
      end
    end
  end

  task automatic xlate(input logic [15:0] seg, input logic [15:0] off, input logic [1:0] acc,
                       input bit fetch, input logic [2:0] f, input logic [31:0] pa, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_seg = seg; req_off = off; req_acc = acc;
    while (!req_ready) @(negedge clk);
    e.f = f; e.pa = pa; e.tag = tag;
    sb_q.push_back(e);
    if (fetch) begin
      addr_q.push_back(TBASE + {13'd0, seg, 3'd0});
      exp_fetches++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (sb_q.size() != 0 && n < 200) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    checks++;
    if (req_ready !== 1'b1 || resp_valid !== 1'b0 || mem_req_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset outputs actual=%b%b%b expected=100", req_ready, resp_valid, mem_req_valid);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R11: length zero after reset
    xlate(16'd0, 16'h0010, 2'd0, 0, 3'd1, 32'h0, "R11 unloaded table");
    drain();
    // R12 load
    @(negedge clk);
    cfg_load = 1'b1; cfg_tbl_base = TBASE; cfg_tbl_len = 17'd5;
    @(negedge clk);
    cfg_load = 1'b0;
    xlate(16'd0, 16'h0010, 2'd0, 1, 3'd0, 32'h0010_0010, "R8 read ok");
    xlate(16'd0, 16'h00FF, 2'd1, 1, 3'd0, 32'h0010_00FF, "R6 limit-1 write ok");
    xlate(16'd0, 16'h0100, 2'd0, 1, 3'd3, 32'h0, "R6 offset at limit");
    xlate(16'd0, 16'h0010, 2'd2, 1, 3'd4, 32'h0, "R7 exec denied");
    xlate(16'd1, 16'h07FF, 2'd2, 1, 3'd0, 32'h0020_07FF, "R7 exec ok");
    xlate(16'd1, 16'h0020, 2'd1, 1, 3'd4, 32'h0, "R7 write denied");
    xlate(16'd0, 16'h0010, 2'd3, 1, 3'd4, 32'h0, "R7 reserved kind");
    xlate(16'd2, 16'h0005, 2'd0, 1, 3'd2, 32'h0, "R5 R9 invalid beats bounds");
    xlate(16'd4, 16'h0020, 2'd1, 1, 3'd3, 32'h0, "R9 bounds beats perm");
    xlate(16'd4, 16'h0008, 2'd0, 1, 3'd4, 32'h0, "R4 no perms");
    xlate(16'd3, 16'h0200, 2'd0, 1, 3'd0, 32'h0000_0100, "R8 wrap");
    xlate(16'd5, 16'h0000, 2'd0, 0, 3'd1, 32'h0, "R2 seg equals length");
    xlate(16'hFFFF, 16'h0000, 2'd0, 0, 3'd1, 32'h0, "R2 max seg");
    xlate(16'd1, 16'h0100, 2'd0, 1, 3'd0, 32'h0020_0100, "R10 back to back");
    drain();
    // R12 reload shrinks the table
    @(negedge clk);
    cfg_load = 1'b1; cfg_tbl_len = 17'd3;
    @(negedge clk);
    cfg_load = 1'b0;
    xlate(16'd3, 16'h0200, 2'd0, 0, 3'd1, 32'h0, "R12 reload length");
    xlate(16'd2, 16'h0000, 2'd0, 1, 3'd2, 32'h0, "R12 seg below new length");
    drain();
    checks++;
    if (fetches != exp_fetches || sb_q.size() != 0) begin
      errors++;
      $display("FAIL R2 fetch count actual=%0d expected=%0d (pending %0d)", fetches, exp_fetches, sb_q.size());
    end
    finish_run();
  end
endmodule